// File: doc/BRIEF.md
# Timed Safety and Response Property Monitor

This block watches a sampled, signed fixed-point quantity, for example a motor's angular velocity, while a controller under test runs. It reaches pass or fail decisions on two timed properties as the samples arrive. The ceiling property holds as long as no sample has ever been above a fixed upper limit. The response property starts each time an action pulse arrives. From then on, samples are counted on a clock that only moves on sample strobes. The samples in an initial settling window are ignored. After that, the first sample strictly inside a target band decides the trial as passed. If the deadline sample arrives without such a sample, the trial fails.

Each property works like a small timed automaton. A free-running tick counter records how many strobes have arrived. At each trigger the response automaton stores a snapshot of that counter, and the elapsed time is the difference between the counter and the snapshot. A verdict starts as satisfied and stays low once it has been falsified. Every verdict is a register. A strobe presented at clock edge E is reflected on the outputs after edge E+1.

Top module: `timed_prop_monitor`

## Requirements
- R1: After reset, `ceil_ok` is 1, `resp_ok` is 1 and `resp_done` is 0.
- R2: A strobed sample greater than CEIL_Q (12.0, which is 3072 in signed Q8.8) drives `ceil_ok` to 0 after the second clock edge following the strobe. A sample of exactly 12.0, or any negative sample, leaves it at 1.
- R3: Once `ceil_ok` is 0, it stays 0 until reset, whatever samples follow.
- R4: `smp_val` has no effect on any verdict while `smp_vld` is 0.
- R5: After a trigger, the strobed samples numbered 1 to WAIT_TICKS-1 are not evaluated, even when they are inside the band.
- R6: A sample numbered from WAIT_TICKS to DEADLINE_TICKS decides the trial as passed if it is strictly inside the band (greater than 2304 and less than 2816 in Q8.8, that is between 9.0 and 11.0). The decision sets `resp_done` to 1 and leaves `resp_ok` unchanged. The values 9.0 and 11.0 themselves are outside the band.
- R7: If sample number DEADLINE_TICKS arrives and it is outside the band, `resp_ok` goes to 0 and `resp_done` goes to 1.
- R8: Once `resp_ok` is 0, it stays 0 until reset, even if a later trial passes.
- R9: An `act_start` pulse clears `resp_done` and restarts the strobe count. A sample strobed in the same cycle as the pulse is not counted.
- R10: A trigger that arrives while a trial is still open abandons that trial and starts the count again from zero.
- R11: The response clock advances only on strobes. Clock cycles with no strobe do not bring the deadline closer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| smp_val | input | DATA_W | Signed fixed-point sample, FRAC_W fractional bits |
| act_start | input | 1 | Triggering action pulse; starts a response trial |
| ceil_ok | output | 1 | Ceiling property verdict (1 = satisfied) |
| resp_ok | output | 1 | Response property verdict (1 = satisfied) |
| resp_done | output | 1 | The current response trial has been decided |

## Verification
The hardest cases to reach from the ports are the exact count boundaries of a trial. One is the strobe numbered WAIT_TICKS, which is the first sample evaluated. Another is the strobe numbered DEADLINE_TICKS, which is the last chance to pass. The third is a trigger that falls in the same cycle as a strobe. The bench counts every strobe it issues after a trigger, so it can place in-band, band-edge and out-of-band values on exactly those sample numbers. It also mixes in strobe-free idle cycles and mid-trial triggers. These show that only counted strobes move the deadline.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_WAIT  = 2'd1,
    RSP_CHECK = 2'd2,
    RSP_DONE  = 2'd3
  } rsp_state_e;

  typedef struct packed {
    logic vld;
    logic act;
    logic over;
    logic inband;
  } smp_flags_t;

endpackage

// File: rtl/tpm_sample_stage.sv
module tpm_sample_stage
  import tpm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BAND_LO = 2304,
  parameter int BAND_HI = 2816,
  parameter int CEIL_Q  = 3072
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_val,
  input  logic              act_start,
  output smp_flags_t        flags_q
);

  logic signed [DATA_W-1:0] val_s;
  logic                     above_ceil;
  logic                     in_band;

  assign val_s      = smp_val;
  assign above_ceil = (int'(val_s) > CEIL_Q);
  assign in_band    = (int'(val_s) > BAND_LO) && (int'(val_s) < BAND_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else begin
      flags_q.vld    <= smp_vld;
      flags_q.act    <= act_start;
      flags_q.over   <= smp_vld && above_ceil;
      flags_q.inband <= smp_vld && in_band;
    end
  end

  AST_BAND_BELOW_CEIL: assert property (@(posedge clk) disable iff (rst)
    flags_q.over |-> !flags_q.inband); // R6

endmodule

// File: rtl/tpm_tick_clock.sv
module tpm_tick_clock #(
  parameter int CLK_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CLK_W-1:0] now_q
);

  always_ff @(posedge clk) begin
    if (rst)       now_q <= '0;
    else if (tick) now_q <= now_q + 1'b1;
  end

  AST_NOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(now_q)); // R11

endmodule

// File: rtl/tpm_ceiling_prop.sv
module tpm_ceiling_prop
  import tpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  smp_flags_t flags,
  output logic       ok_q
);

  always_ff @(posedge clk) begin
    if (rst)                        ok_q <= 1'b1;
    else if (flags.vld && flags.over) ok_q <= 1'b0;
  end

  AST_CEIL_TRIP: assert property (@(posedge clk) disable iff (rst)
    (flags.vld && flags.over) |=> !ok_q); // R2

  AST_CEIL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ok_q |=> !ok_q); // R3

endmodule

// File: rtl/tpm_response_prop.sv
module tpm_response_prop
  import tpm_pkg::*;
#(
  parameter int CLK_W          = 8,
  parameter int WAIT_TICKS     = 50,
  parameter int DEADLINE_TICKS = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  smp_flags_t       flags,
  input  logic [CLK_W-1:0] now,
  output logic             ok_q,
  output logic             done_q
);

  localparam logic [CLK_W-1:0] WAIT_C = CLK_W'(WAIT_TICKS);
  localparam logic [CLK_W-1:0] DL_C   = CLK_W'(DEADLINE_TICKS);

  rsp_state_e       st_q;
  logic [CLK_W-1:0] mark_q;
  logic [CLK_W-1:0] elapsed;
  logic             open;

  assign elapsed = now - mark_q;
  assign open    = (st_q == RSP_WAIT) || (st_q == RSP_CHECK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= RSP_IDLE;
      mark_q <= '0;
      ok_q   <= 1'b1;
      done_q <= 1'b0;
    end else if (flags.act) begin
      st_q   <= RSP_WAIT;
      mark_q <= now;
      done_q <= 1'b0;
    end else if (flags.vld && open) begin
      if (elapsed < WAIT_C) begin
        st_q <= RSP_WAIT;
      end else if (flags.inband) begin
        st_q   <= RSP_DONE;
        done_q <= 1'b1;
      end else if (elapsed >= DL_C) begin
        st_q   <= RSP_DONE;
        done_q <= 1'b1;
        ok_q   <= 1'b0;
      end else begin
        st_q <= RSP_CHECK;
      end
    end
  end

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ok_q |=> !ok_q); // R8

  AST_ACT_RESTART: assert property (@(posedge clk) disable iff (rst)
    flags.act |=> (st_q == RSP_WAIT) && !done_q); // R9

  AST_DEADLINE_BOUND: assert property (@(posedge clk) disable iff (rst)
    open |-> (elapsed <= DL_C)); // R7

  AST_EARLY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (flags.vld && !flags.act && st_q == RSP_WAIT && elapsed < WAIT_C) |=> !done_q); // R5

  AST_FAIL_DECIDES: assert property (@(posedge clk) disable iff (rst)
    $fell(ok_q) |-> done_q); // R7

  initial begin
    assert (WAIT_TICKS >= 1 && WAIT_TICKS <= DEADLINE_TICKS); // R5
  end

endmodule

// File: rtl/timed_prop_monitor.sv
module timed_prop_monitor
  import tpm_pkg::*;
#(
  parameter int DATA_W         = 16,
  parameter int FRAC_W         = 8,
  parameter int BAND_LO_INT    = 9,
  parameter int BAND_HI_INT    = 11,
  parameter int CEIL_INT       = 12,
  parameter int WAIT_TICKS     = 50,
  parameter int DEADLINE_TICKS = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_val,
  input  logic              act_start,
  output logic              ceil_ok,
  output logic              resp_ok,
  output logic              resp_done
);

  localparam int BAND_LO_Q = BAND_LO_INT << FRAC_W;
  localparam int BAND_HI_Q = BAND_HI_INT << FRAC_W;
  localparam int CEIL_Q    = CEIL_INT << FRAC_W;
  localparam int CLK_W     = $clog2(DEADLINE_TICKS + 1) + 1;

  smp_flags_t       flags;
  logic [CLK_W-1:0] now;

  tpm_sample_stage #(
    .DATA_W (DATA_W),
    .BAND_LO(BAND_LO_Q),
    .BAND_HI(BAND_HI_Q),
    .CEIL_Q (CEIL_Q)
  ) u_stage (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .smp_val  (smp_val),
    .act_start(act_start),
    .flags_q  (flags)
  );

  tpm_tick_clock #(.CLK_W(CLK_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (smp_vld),
    .now_q(now)
  );

  tpm_ceiling_prop u_ceil (
    .clk  (clk),
    .rst  (rst),
    .flags(flags),
    .ok_q (ceil_ok)
  );

  tpm_response_prop #(
    .CLK_W         (CLK_W),
    .WAIT_TICKS    (WAIT_TICKS),
    .DEADLINE_TICKS(DEADLINE_TICKS)
  ) u_resp (
    .clk   (clk),
    .rst   (rst),
    .flags (flags),
    .now   (now),
    .ok_q  (resp_ok),
    .done_q(resp_done)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (ceil_ok && resp_ok && !resp_done)); // R1

endmodule

// File: tb/sim_timed_prop_monitor.sv
module sim_timed_prop_monitor;

  localparam int WAIT_T = 50;
  localparam int DL_T   = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_vld = 1'b0;
  logic [15:0] smp_val = '0;
  logic        act_start = 1'b0;
  logic        ceil_ok, resp_ok, resp_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  timed_prop_monitor #(.WAIT_TICKS(WAIT_T), .DEADLINE_TICKS(DL_T)) u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_val(smp_val),
    .act_start(act_start), .ceil_ok(ceil_ok), .resp_ok(resp_ok),
    .resp_done(resp_done)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [15:0] v);
    smp_vld = 1'b1; smp_val = v;
    @(negedge clk);
    smp_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_n(input int n, input logic [15:0] v);
    for (int i = 0; i < n; i++) send(v);
  endtask

  task automatic trigger();
    act_start = 1'b1;
    @(negedge clk);
    act_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ceil_ok", ceil_ok, 1'b1);
    chk("R1 resp_ok", resp_ok, 1'b1);
    chk("R1 resp_done", resp_done, 1'b0);
  endtask

  task automatic t_ceiling();
    do_reset();
    send(16'd3072);
    chk("R2 exactly 12.0", ceil_ok, 1'b1);
    send(16'hF060);
    chk("R2 negative sample", ceil_ok, 1'b1);
    smp_val = 16'd4000;
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk("R4 unstrobed value", ceil_ok, 1'b1);
    send(16'd3073);
    chk("R2 above ceiling", ceil_ok, 1'b0);
    send(16'd1280);
    chk("R3 stays low", ceil_ok, 1'b0);
    chk("R4 resp untouched", resp_ok, 1'b1);
  endtask

  task automatic t_pass();
    do_reset();
    trigger();
    send_n(WAIT_T - 1, 16'd2560);
    chk("R5 early in-band ignored", resp_done, 1'b0);
    send(16'd2304);
    chk("R6 lower edge not in band", resp_done, 1'b0);
    send(16'd2816);
    chk("R6 upper edge not in band", resp_done, 1'b0);
    send(16'd2560);
    chk("R6 pass done", resp_done, 1'b1);
    chk("R6 pass ok", resp_ok, 1'b1);
  endtask

  task automatic t_deadline();
    do_reset();
    trigger();
    send_n(DL_T - 1, 16'd1280);
    chk("R7 before deadline done", resp_done, 1'b0);
    chk("R7 before deadline ok", resp_ok, 1'b1);
    for (int i = 0; i < 20; i++) @(negedge clk);
    chk("R11 idle cycles", resp_done, 1'b0);
    send(16'd1280);
    chk("R7 deadline done", resp_done, 1'b1);
    chk("R7 deadline fail", resp_ok, 1'b0);
    trigger();
    chk("R9 trigger clears done", resp_done, 1'b0);
    send_n(WAIT_T, 16'd2560);
    chk("R8 later pass done", resp_done, 1'b1);
    chk("R8 verdict stays low", resp_ok, 1'b0);
  endtask

  task automatic t_deadline_pass();
    do_reset();
    trigger();
    send_n(DL_T - 1, 16'd1280);
    send(16'd2600);
    chk("R6 pass on deadline sample done", resp_done, 1'b1);
    chk("R6 pass on deadline sample ok", resp_ok, 1'b1);
  endtask

  task automatic t_restart();
    do_reset();
    trigger();
    send_n(60, 16'd1280);
    trigger();
    send_n(WAIT_T - 1, 16'd2560);
    chk("R10 restarted count", resp_done, 1'b0);
    send(16'd2560);
    chk("R10 pass after restart", resp_done, 1'b1);
    chk("R10 ok after restart", resp_ok, 1'b1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    act_start = 1'b1; smp_vld = 1'b1; smp_val = 16'd2560;
    @(negedge clk);
    act_start = 1'b0; smp_vld = 1'b0;
    @(negedge clk);
    send_n(WAIT_T - 1, 16'd2560);
    chk("R9 coincident sample not counted", resp_done, 1'b0);
    send(16'd2560);
    chk("R9 pass at count", resp_done, 1'b1);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ceiling();
    t_pass();
    t_deadline();
    t_deadline_pass();
    t_restart();
    t_same_cycle();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule